// File: doc/BRIEF.md
# Two-Mode Class Scheduler for a Shared Output Link

This block decides which of several class queues may place its next packet on a single output link. Each queue reports only whether it holds a packet, and software provides an integer weight for each class. A mode input selects between two policies. In the first, a fixed ranking applies: class 0 ranks highest and class N-1 ranks lowest. In the second, the block moves around the classes in a circle and gives each non-empty class a burst of up to its weight in packets before it moves on.

A decision produces a one-cycle valid strobe and a class index. The index stays on the output until the next decision. After a grant the link is owned by that packet. The environment reports the end of the packet with a done pulse, and no other grant is made before that pulse arrives. The block makes a decision on every clock edge at which the link is free, or at which the current packet reports done, and at least one class is eligible. Back-to-back packets therefore leave no gap on the link.

Top module: `cls_sched`

## Requirements
- R1: While reset is asserted and after it is released, grant_valid is 0 and grant_class is 0. The rotation pointer starts at class 0 with no packets counted against the current visit.
- R2: When wrr_mode is 0 at a decision, the granted class is the lowest-index class whose class_ready bit is 1.
- R3: In ranked mode, a class that stays non-empty is granted at every decision, so lower classes are not served until it empties.
- R4: When wrr_mode is 1, the rotation moves upward through the class indices and wraps from N-1 to 0. A class with class_ready 0 is skipped.
- R5: In rotation mode, a class gets up to its weight in consecutive grants per visit. The weight of class i is class_weight[i*WW +: WW]. The pointer then moves to the next eligible class. If that is the same class, a fresh visit begins.
- R6: If the visited class reports empty while it still has credit, the unused credit is dropped and the next eligible class is served.
- R7: A class whose weight is 0 is never granted in rotation mode. The weight has no effect in ranked mode.
- R8: Between a grant and the following pkt_done, no further grant is issued. pkt_done while the link is free has no effect.
- R9: At a clock edge where the link is free, or where pkt_done is 1, grant_valid is 1 in the next cycle whenever at least one class is eligible.
- R10: The rotation pointer and the visit count keep their values across idle periods and across grants made in ranked mode. wrr_mode is used only at decision edges.
- R11: grant_valid is high for exactly one cycle per grant. grant_class keeps its value while grant_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrr_mode | input | 1 | 0 selects ranked service, 1 selects weighted rotation |
| class_ready | input | N | Bit i is 1 when queue i holds at least one packet |
| class_weight | input | N*WW | Packed per-class weights, class i in bits [i*WW +: WW] |
| pkt_done | input | 1 | The packet on the link finishes in this cycle |
| grant_valid | output | 1 | One-cycle strobe marking a new grant |
| grant_class | output | clog2(N) | Index of the most recently granted class |

## Verification
A grant is due one clock after the decision edge. That edge is either the first edge at which the link is free or the edge at which pkt_done is sampled high. The bench sets inputs at the falling edge, advances its reference model one step for the coming rising edge, and compares grant_valid and grant_class at the next falling edge. Every comparison therefore looks at the result exactly one register stage after the inputs that caused it. The bench models each queue as a packet count and returns the done pulse a fixed number of cycles after each observed grant. It also checks the recorded order of grants against hand-derived sequences for ranked exhaustion, weighted bursts, forfeited credit and a pointer that persists across an idle period.

// File: rtl/cls_sched_pkg.sv
package cls_sched_pkg;

   typedef enum logic {
      LINK_FREE = 1'b0,
      LINK_HELD = 1'b1
   } link_state_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/cls_prio_pick.sv
module cls_prio_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 2
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [CW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = CW'(i);
         end
      end
   end

endmodule

// File: rtl/cls_rr_pick.sv
module cls_rr_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned CW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [CW-1:0] base,
   output logic          found,
   output logic [CW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = base;
      for (int k = N; k >= 1; k--) begin
         if (req[(int'(base) + k) % N]) begin
            found = 1'b1;
            idx   = CW'((int'(base) + k) % N);
         end
      end
   end

endmodule

// File: rtl/cls_wrr_credit.sv
module cls_wrr_credit #(
   parameter int unsigned N  = 4,
   parameter int unsigned WW = 4,
   parameter int unsigned CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          advance,
   input  logic [N-1:0]  elig,
   input  logic [WW-1:0] wts [N],
   output logic          pick_any,
   output logic [CW-1:0] pick_idx
);

   logic [CW-1:0] ptr_q;
   logic [WW-1:0] used_q;
   logic          stay;
   logic          nxt_found;
   logic [CW-1:0] nxt_idx;

   cls_rr_pick #(.N(N), .CW(CW)) u_scan (
      .req   (elig),
      .base  (ptr_q),
      .found (nxt_found),
      .idx   (nxt_idx)
   );

   assign stay     = elig[ptr_q] && (used_q < wts[ptr_q]);
   assign pick_any = stay || nxt_found;
   assign pick_idx = stay ? ptr_q : nxt_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         used_q <= '0;
      end else if (advance) begin
         if (stay) begin
            used_q <= used_q + WW'(1);
         end else begin
            ptr_q  <= nxt_idx;
            used_q <= WW'(1);
         end
      end
   end

endmodule

// File: rtl/cls_sched.sv
module cls_sched #(
   parameter int unsigned N  = 4,
   parameter int unsigned WW = 4,
   localparam int unsigned CW = cls_sched_pkg::idx_bits(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wrr_mode,
   input  logic [N-1:0]    class_ready,
   input  logic [N*WW-1:0] class_weight,
   input  logic            pkt_done,
   output logic            grant_valid,
   output logic [CW-1:0]   grant_class
);
   import cls_sched_pkg::*;

   if (N < 2) begin : g_bad_n
      $error("cls_sched: N must be at least 2");
   end
   if (WW < 1) begin : g_bad_ww
      $error("cls_sched: WW must be at least 1");
   end

   logic [WW-1:0] wts [N];
   logic [N-1:0]  wt_live;

   for (genvar g = 0; g < N; g++) begin : g_unpack
      assign wts[g]     = class_weight[g*WW +: WW];
      assign wt_live[g] = |class_weight[g*WW +: WW];
   end

   link_state_e   state_q;
   logic          decide;
   logic [N-1:0]  elig;
   logic          any_elig;
   logic          p_found;
   logic [CW-1:0] p_idx;
   logic          r_found;
   logic [CW-1:0] r_idx;
   logic [CW-1:0] chosen;

   assign decide   = (state_q == LINK_FREE) || pkt_done;
   assign elig     = wrr_mode ? (class_ready & wt_live) : class_ready;
   assign any_elig = wrr_mode ? r_found : p_found;
   assign chosen   = wrr_mode ? r_idx : p_idx;

   cls_prio_pick #(.N(N), .CW(CW)) u_rank (
      .req   (class_ready),
      .found (p_found),
      .idx   (p_idx)
   );

   cls_wrr_credit #(.N(N), .WW(WW), .CW(CW)) u_rot (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (decide && wrr_mode && r_found),
      .elig     (elig),
      .wts      (wts),
      .pick_any (r_found),
      .pick_idx (r_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= LINK_FREE;
         grant_valid <= 1'b0;
         grant_class <= '0;
      end else if (decide) begin
         if (any_elig) begin
            state_q     <= LINK_HELD;
            grant_valid <= 1'b1;
            grant_class <= chosen;
         end else begin
            state_q     <= LINK_FREE;
            grant_valid <= 1'b0;
         end
      end else begin
         grant_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/cls_sched_chk.sv
module cls_sched_chk #(
   parameter int unsigned N  = 4,
   parameter int unsigned WW = 4,
   parameter int unsigned CW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wrr_mode,
   input logic [N-1:0]    class_ready,
   input logic [N*WW-1:0] class_weight,
   input logic            pkt_done,
   input logic            grant_valid,
   input logic [CW-1:0]   grant_class
);

   logic          held_q;
   logic          link_used;
   logic [N-1:0]  nz_w;
   logic [N-1:0]  sel_mask;
   logic [N-1:0]  below_mask;
   logic [N-1:0]  ok_now;

   for (genvar g = 0; g < N; g++) begin : g_nz
      assign nz_w[g] = |class_weight[g*WW +: WW];
   end

   assign link_used  = grant_valid || held_q;
   assign sel_mask   = N'(1) << grant_class;
   assign below_mask = sel_mask - N'(1);
   assign ok_now     = wrr_mode ? (class_ready & nz_w) : class_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= link_used && !pkt_done;
   end

   a_r2_rank_top: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !$past(wrr_mode)) |-> (($past(class_ready) & below_mask) == '0));

   a_r4_served_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (($past(class_ready) & sel_mask) != '0));

   a_r7_zero_weight_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && $past(wrr_mode)) |-> (($past(nz_w) & sel_mask) != '0));

   a_r8_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (!$past(link_used) || $past(pkt_done)));

   a_r9_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
      ((!link_used || pkt_done) && (|ok_now)) |=> grant_valid);

   a_r11_index_held: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> $stable(grant_class));

endmodule

bind cls_sched cls_sched_chk #(.N(N), .WW(WW), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wrr_mode     (wrr_mode),
   .class_ready  (class_ready),
   .class_weight (class_weight),
   .pkt_done     (pkt_done),
   .grant_valid  (grant_valid),
   .grant_class  (grant_class)
);

// File: tb/tb_cls_sched.sv
module tb_cls_sched;
   localparam int N  = 4;
   localparam int WW = 4;
   localparam int CW = 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            wrr_mode;
   logic [N-1:0]    class_ready;
   logic [N*WW-1:0] class_weight;
   logic            pkt_done;
   logic            grant_valid;
   logic [CW-1:0]   grant_class;

   always #4 clk = ~clk;

   cls_sched #(.N(N), .WW(WW)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wrr_mode     (wrr_mode),
      .class_ready  (class_ready),
      .class_weight (class_weight),
      .pkt_done     (pkt_done),
      .grant_valid  (grant_valid),
      .grant_class  (grant_class)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   int q_cnt [N];
   int m_ptr = 0, m_used = 0;
   bit m_busy = 0;
   int e_valid = 0, e_class = 0;
   bit env_busy = 0;
   int env_left = 0;
   int log_g [16];
   int log_n = 0;

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int wt(input int i);
      return int'(class_weight[i*WW +: WW]);
   endfunction

   task automatic model_step();
      bit el [N];
      bit any;
      int pick;
      any  = 0;
      pick = 0;
      e_valid = 0;
      if (!m_busy || pkt_done) begin
         for (int i = 0; i < N; i++)
            el[i] = class_ready[i] && (!wrr_mode || wt(i) > 0);
         if (!wrr_mode) begin
            for (int i = N - 1; i >= 0; i--)
               if (el[i]) begin any = 1; pick = i; end
         end else if (el[m_ptr] && m_used < wt(m_ptr)) begin
            any = 1; pick = m_ptr; m_used++;
         end else begin
            for (int k = N; k >= 1; k--)
               if (el[(m_ptr + k) % N]) begin any = 1; pick = (m_ptr + k) % N; end
            if (any) begin m_ptr = pick; m_used = 1; end
         end
         m_busy = any;
         if (any) begin e_valid = 1; e_class = pick; end
      end
   endtask

   task automatic run_phase(input string tag, input bit mode, input int len,
                            input int cycles, input bit idle_done, input bit flip);
      log_n = 0;
      for (int c = 0; c < cycles; c++) begin
         for (int i = 0; i < N; i++) class_ready[i] = (q_cnt[i] > 0);
         wrr_mode = flip ? bit'(c % 2) : mode;
         pkt_done = env_busy ? (env_left == 1) : (idle_done && (c % 3 == 0));
         model_step();
         @(negedge clk);
         chk({tag, " grant_valid"}, int'(grant_valid), e_valid);
         chk({tag, " grant_class"}, int'(grant_class), e_class);
         if (env_busy && pkt_done) env_busy = 0;
         else if (env_busy) env_left--;
         if (grant_valid) begin
            env_busy = 1;
            env_left = len;
            if (q_cnt[grant_class] > 0) q_cnt[grant_class]--;
            if (log_n < 16) begin log_g[log_n] = int'(grant_class); log_n++; end
         end
      end
   endtask

   task automatic chk_order(input string tag, input int exp [], input int n);
      chk({tag, " grant count"}, log_n < n ? log_n : n, n);
      for (int i = 0; i < n && i < log_n; i++) chk({tag, " order"}, log_g[i], exp[i]);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int exp [];
      rst_n = 0; wrr_mode = 0; class_ready = '0; class_weight = '0; pkt_done = 0;
      for (int i = 0; i < N; i++) q_cnt[i] = 0;
      repeat (3) @(negedge clk);
      chk("R1 reset grant_valid", int'(grant_valid), 0);
      chk("R1 reset grant_class", int'(grant_class), 0);
      rst_n = 1;

      // R2 R3: ranked, exhaustive service of the top class
      q_cnt = '{2, 3, 1, 4};
      run_phase("R2 R3 ranked", 1'b0, 2, 30, 1'b0, 1'b0);
      exp = '{0, 0, 1, 1, 1, 2, 3, 3, 3, 3};
      chk_order("R3 exhaustive", exp, 10);

      // R4 R5 R7: weights 3,1,2,0, back-to-back packets
      class_weight = 16'h0213;
      q_cnt = '{8, 8, 8, 8};
      run_phase("R4 R5 R7 rotation", 1'b1, 1, 14, 1'b0, 1'b0);
      exp = '{0, 0, 0, 1, 2, 2, 0, 0, 0, 1, 2, 2};
      chk_order("R5 weighted bursts", exp, 12);

      // R6: class empties mid-visit, credit dropped
      class_weight = 16'h2224;
      q_cnt = '{2, 1, 3, 0};
      run_phase("R6 forfeit", 1'b1, 2, 20, 1'b0, 1'b0);
      exp = '{0, 0, 1, 2, 2, 2};
      chk_order("R6 forfeit", exp, 6);

      // R8 R9: idle link, stray pkt_done ignored
      q_cnt = '{0, 0, 0, 0};
      run_phase("R8 idle done ignored", 1'b1, 1, 10, 1'b1, 1'b0);
      chk("R8 no grant while idle", log_n, 0);

      // R10: pointer kept on class 2 with one packet used
      q_cnt = '{1, 1, 1, 1};
      run_phase("R10 persist", 1'b1, 1, 8, 1'b0, 1'b0);
      exp = '{2, 3, 0, 1};
      chk_order("R10 persist", exp, 4);

      // R10 R11: mode toggles every cycle during long packets
      class_weight = 16'h1111;
      q_cnt = '{3, 3, 0, 2};
      run_phase("R10 R11 mode flip", 1'b0, 4, 40, 1'b0, 1'b1);

      // R7: zero weights do not matter in ranked mode
      class_weight = '0;
      q_cnt = '{0, 2, 0, 0};
      run_phase("R7 ranked zero weight", 1'b0, 2, 8, 1'b0, 1'b0);
      exp = '{1, 1};
      chk_order("R7 ranked zero weight", exp, 2);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule